// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block guards a small on-chip configuration array and a 64-bit signature register behind one command port. A requester presents a 3-bit command code together with an address, write data and a lock flag, and raises `cmd_valid`. The controller takes the command when it is ready and performs it in a single cycle. In the cycle after acceptance it returns a one-cycle response carrying read data and an error flag.

A sticky security bit protects the array. It can be set on its own, or as the last step of a program command. Once it is set, reads and writes of the array are refused, and so is rewriting the signature. The only way back is a bulk erase, which returns every array word to the erased value and clears the bit in the same operation. The signature remains readable in every state, so software can still identify what was loaded into a locked part.

Top module: `cfg_guard`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_valid` is 0. Every array word reads back as all ones, the security bit is clear and all four signature slices read zero.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. In the cycle that follows, `rsp_valid` is 1 and `cmd_ready` is 0. In the cycle after that, `rsp_valid` is 0 and `cmd_ready` is 1 again.
- R3: With the security bit clear, program (code 0) stores `cmd_wdata` at `cmd_addr`, and verify (code 1) returns the word stored at `cmd_addr`.
- R4: Set-security (code 2) sets the security bit in every state and never reports an error. A program command accepted with `cmd_lock` = 1 while the bit is clear writes its word first and then sets the bit.
- R5: While the security bit is set, verify (code 1) is refused.
- R6: While the security bit is set, program (code 0) is refused, and it leaves the security bit set whatever `cmd_lock` holds.
- R7: Bulk erase (code 3) is always accepted. It sets every array word to all ones, clears the security bit and leaves the signature unchanged.
- R8: Program-signature (code 4) writes `cmd_wdata` to signature slice k = `cmd_addr[1:0]`, which holds signature bits 16k+15 down to 16k. It is refused while the security bit is set.
- R9: Read-signature (code 5) returns slice `cmd_addr[1:0]` and succeeds in every state, including while the security bit is set.
- R10: Codes 6 and 7 are refused and change neither the array, the signature nor the security bit.
- R11: A refused command raises `rsp_err` during its response cycle only, with `rsp_rdata` at zero. Successful commands other than verify and read-signature return `rsp_rdata` = 0 with `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_code | input | 3 | Command code (0..5 defined) |
| cmd_addr | input | ADDR_W (4) | Array word address; low two bits select the signature slice |
| cmd_wdata | input | DATA_W (16) | Write data for program commands |
| cmd_lock | input | 1 | With program: set the security bit after writing |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | DATA_W (16) | Read data, zero on refusal and on write-type commands |
| rsp_err | output | 1 | Command was refused |

## Verification
The bench covers the transitions into and out of the locked state. It sets the lock both by the dedicated command and by a program with the lock flag, then tries every array access and a signature write while locked. A design that checked the lock before a lock-flagged program had written would lose that word. One that blocked only writes would leak array contents through verify. After an erase, the bench checks that the array is back to all ones, that the signature survived and that programming works again. A design that cleared the signature, or left stale words in place, would show wrong read data there. Unused codes and random mixes of all commands check that refusals return zero data, and that the one-cycle response never stalls the handshake or stretches it.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_PROG     = 3'd0,
        CMD_VERIFY   = 3'd1,
        CMD_LOCK     = 3'd2,
        CMD_ERASE    = 3'd3,
        CMD_SIG_PROG = 3'd4,
        CMD_SIG_READ = 3'd5
    } cmd_e;
endpackage

// File: rtl/cfg_guard_array.sv
// Configuration word store with single-word write and whole-array erase.
module cfg_guard_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase)
                mem_d[i] = '1;
            else if (we && (addr == ADDR_W'(i)))
                mem_d[i] = wdata;
            else
                mem_d[i] = mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '1;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/cfg_guard_sig.sv
// Signature register, written and read one DATA_W slice at a time.
module cfg_guard_sig #(
    parameter int SIG_W  = 64,
    parameter int DATA_W = 16,
    localparam int SLICES = SIG_W / DATA_W,
    localparam int SEL_W  = $clog2(SLICES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slice_q [SLICES];

    genvar g;
    generate
        for (g = 0; g < SLICES; g++) begin : g_slice
            logic [DATA_W-1:0] slice_d;
            always_comb begin
                slice_d = slice_q[g];
                if (we && (sel == SEL_W'(g))) slice_d = wdata;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) slice_q[g] <= '0;
                else        slice_q[g] <= slice_d;
            end
        end
    endgenerate

    assign rdata = slice_q[sel];
endmodule

// File: rtl/cfg_guard_ctrl.sv
// Command decode, security bit and one-cycle response register.
module cfg_guard_ctrl
    import cfg_guard_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              cmd_lock,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] sig_rdata,
    output logic              cmd_ready,
    output logic              arr_we,
    output logic              arr_erase,
    output logic              sig_we,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              busy;
        logic              locked;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;

    always_comb begin
        accept    = cmd_valid && !st_q.busy;
        st_d      = st_q;
        st_d.busy = accept;
        st_d.err  = 1'b0;
        st_d.rdata = '0;
        arr_we    = 1'b0;
        arr_erase = 1'b0;
        sig_we    = 1'b0;
        if (accept) begin
            case (cmd_e'(cmd_code))
                CMD_PROG: begin
                    if (st_q.locked) st_d.err = 1'b1;
                    else begin
                        arr_we = 1'b1;
                        if (cmd_lock) st_d.locked = 1'b1;
                    end
                end
                CMD_VERIFY: begin
                    if (st_q.locked) st_d.err = 1'b1;
                    else             st_d.rdata = arr_rdata;
                end
                CMD_LOCK:  st_d.locked = 1'b1;
                CMD_ERASE: begin
                    arr_erase   = 1'b1;
                    st_d.locked = 1'b0;
                end
                CMD_SIG_PROG: begin
                    if (st_q.locked) st_d.err = 1'b1;
                    else             sig_we = 1'b1;
                end
                CMD_SIG_READ: st_d.rdata = sig_rdata;
                default:      st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_ready = !st_q.busy;
    assign rsp_valid = st_q.busy;
    assign rsp_err   = st_q.err;
    assign rsp_rdata = st_q.rdata;
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int SIG_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_lock,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int SEL_W = $clog2(SIG_W / DATA_W);

    logic              arr_we, arr_erase, sig_we;
    logic [DATA_W-1:0] arr_rdata, sig_rdata;

    cfg_guard_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_lock(cmd_lock), .arr_rdata(arr_rdata), .sig_rdata(sig_rdata),
        .cmd_ready(cmd_ready), .arr_we(arr_we), .arr_erase(arr_erase),
        .sig_we(sig_we), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    cfg_guard_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .erase(arr_erase),
        .addr(cmd_addr), .wdata(cmd_wdata), .rdata(arr_rdata)
    );

    cfg_guard_sig #(.SIG_W(SIG_W), .DATA_W(DATA_W)) u_sig (
        .clk(clk), .rst_n(rst_n), .we(sig_we), .sel(cmd_addr[SEL_W-1:0]),
        .wdata(cmd_wdata), .rdata(sig_rdata)
    );
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_code,
    input logic              cmd_lock,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic acc;
    logic sec_m;

    assign acc = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) sec_m <= 1'b0;
        else if (acc) begin
            if (cmd_code == 3'd2)                          sec_m <= 1'b1;
            else if (cmd_code == 3'd3)                     sec_m <= 1'b0;
            else if (cmd_code == 3'd0 && cmd_lock)         sec_m <= 1'b1;
        end
    end

    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rsp_valid && !cmd_ready)); // R2
    AST_RESPONSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && cmd_ready)); // R2
    AST_LOCKED_VERIFY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_m && cmd_code == 3'd1) |=> rsp_err); // R5
    AST_LOCKED_PROG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_m && cmd_code == 3'd0) |=> rsp_err); // R6
    AST_ERASE_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_code == 3'd3) |=> !rsp_err); // R7
    AST_LOCKED_SIG_PROG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec_m && cmd_code == 3'd4) |=> rsp_err); // R8
    AST_SIG_READ_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_code == 3'd5) |=> !rsp_err); // R9
    AST_BAD_CODE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_code > 3'd5) |=> rsp_err); // R10
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R11
    AST_LOCK_NEVER_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_code == 3'd2) |=> !rsp_err); // R4
endmodule

bind cfg_guard cfg_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_lock(cmd_lock), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/cfg_guard_bench.sv
module cfg_guard_bench;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_code = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_lock = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_sig [4];
    logic          m_sec;

    always #5 clk = ~clk;

    cfg_guard #(.ADDR_W(AW), .DATA_W(DW), .SIG_W(64)) u_cfg_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_lock(cmd_lock), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic [2:0] code, input logic sec);
        case (code)
            3'd0: return sec ? "R6" : "R3";
            3'd1: return sec ? "R5" : "R3";
            3'd2: return "R4";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Expected response from the requirements; updates the bench model.
    task automatic model(input logic [2:0] code, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input logic lk,
                         output logic e_err, output logic [DW-1:0] e_data);
        e_err = 1'b0;
        e_data = '0;
        case (code)
            3'd0: if (m_sec) e_err = 1'b1;
                  else begin m_mem[addr] = wd; if (lk) m_sec = 1'b1; end
            3'd1: if (m_sec) e_err = 1'b1; else e_data = m_mem[addr];
            3'd2: m_sec = 1'b1;
            3'd3: begin
                for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
                m_sec = 1'b0;
            end
            3'd4: if (m_sec) e_err = 1'b1; else m_sig[addr[1:0]] = wd;
            3'd5: e_data = m_sig[addr[1:0]];
            default: e_err = 1'b1;
        endcase
    endtask

    task automatic do_cmd(input logic [2:0] code, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, input logic lk);
        logic e_err;
        logic [DW-1:0] e_data;
        string tg;
        tg = tag_for(code, m_sec);
        model(code, addr, wd, lk, e_err, e_data);
        cmd_valid = 1'b1; cmd_code = code; cmd_addr = addr;
        cmd_wdata = wd; cmd_lock = lk;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(rsp_valid === 1'b1 && cmd_ready === 1'b0, "R2 busy",
              {14'd0, rsp_valid, cmd_ready}, 16'h0002);
        check(rsp_err === e_err, {tg, " err"}, {15'd0, rsp_err}, {15'd0, e_err});
        check(rsp_rdata === e_data, {tg, " data"}, rsp_rdata, e_data);
        if (e_err)
            check(rsp_rdata === '0, "R11 zero", rsp_rdata, 16'h0);
        @(negedge clk);
        check(rsp_valid === 1'b0 && cmd_ready === 1'b1 && rsp_err === 1'b0,
              "R2 R11 release", {14'd0, rsp_valid, cmd_ready}, 16'h0001);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
        for (int i = 0; i < 4; i++) m_sig[i] = '0;
        m_sec = 1'b0;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R1 idle",
              {14'd0, cmd_ready, rsp_valid}, 16'h0002);
        for (int a = 0; a < DEPTH; a++) do_cmd(3'd1, AW'(a), '0, 1'b0); // R1 all ones
        for (int s = 0; s < 4; s++) do_cmd(3'd5, AW'(s), '0, 1'b0);     // R1 sig zero
        // R3 program and verify
        do_cmd(3'd0, 4'd3, 16'hA5A5, 1'b0);
        do_cmd(3'd1, 4'd3, '0, 1'b0);
        do_cmd(3'd4, 4'd2, 16'h1234, 1'b0);  // R8
        do_cmd(3'd5, 4'd2, '0, 1'b0);
        // R4 program with lock: word written, then locked
        do_cmd(3'd0, 4'd7, 16'h0F0F, 1'b1);
        do_cmd(3'd1, 4'd7, '0, 1'b0);        // R5 refused
        do_cmd(3'd0, 4'd7, 16'h5555, 1'b0);  // R6 refused
        do_cmd(3'd0, 4'd8, 16'h5555, 1'b1);  // R6 refused, stays locked
        do_cmd(3'd4, 4'd2, 16'hFFFF, 1'b0);  // R8 refused
        do_cmd(3'd5, 4'd2, '0, 1'b0);        // R9 readable while locked
        do_cmd(3'd2, 4'd0, '0, 1'b0);        // R4 lock again, no error
        do_cmd(3'd6, 4'd0, '0, 1'b0);        // R10
        do_cmd(3'd7, 4'd0, '0, 1'b0);        // R10
        // R7 erase: array all ones, unlocked, signature kept
        do_cmd(3'd3, 4'd0, '0, 1'b0);
        do_cmd(3'd1, 4'd7, '0, 1'b0);
        do_cmd(3'd1, 4'd3, '0, 1'b0);
        do_cmd(3'd5, 4'd2, '0, 1'b0);
        do_cmd(3'd2, 4'd0, '0, 1'b0);        // R4 via lock command
        do_cmd(3'd1, 4'd3, '0, 1'b0);        // R5
        do_cmd(3'd3, 4'd0, '0, 1'b0);        // R7
        do_cmd(3'd7, 4'd1, 16'hBEEF, 1'b1);  // R10 no change
        do_cmd(3'd1, 4'd1, '0, 1'b0);
        do_cmd(3'd0, 4'd1, 16'h2222, 1'b0);
        // Random mix, erase and lock kept rare
        for (int n = 0; n < 600; n++) begin
            logic [2:0] c;
            int r;
            r = $urandom_range(0, 99);
            if (r < 30)      c = 3'd0;
            else if (r < 55) c = 3'd1;
            else if (r < 60) c = 3'd2;
            else if (r < 66) c = 3'd3;
            else if (r < 78) c = 3'd4;
            else if (r < 94) c = 3'd5;
            else             c = 3'($urandom_range(6, 7));
            do_cmd(c, AW'($urandom), DW'($urandom), ($urandom_range(0, 19) == 0));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule